// File: doc/BRIEF.md
# Two-Stage I2C Serial Clock Generator

This block makes the serial clock timing for an I2C bus master out of a fast system clock. A first stage counts system clocks and emits a one-cycle reference tick. Software picks the prescale so that this tick lands near 10 MHz: round the system clock in MHz, then divide by ten. A second stage builds SCL from that tick. The high half and the low half of the SCL period are each a count of reference ticks, and each is programmed separately through one 16-bit divider word.

For a symmetric bus clock, each half is (10000 / f_kHz + 1) / 2 ticks. At 100 kHz that gives 50 ticks per half. At 20 kHz it gives 250, which still fits in the 8-bit fields. Besides the SCL level, the block gives the bit engine two one-cycle strobes. One marks the middle of the high phase, where SDA is sampled. The other marks the start of the low phase, where SDA may change. A hold input lets the bit engine freeze the low phase, for example while it waits on data. All pins are plain control and status signals: nothing here carries a data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `scl_clkgen`

## Requirements
- R1: During reset and after it, until the generator is enabled, scl_out is 1 and ref_tick, sample_stb and drive_stb are 0.
- R2: While enable is 1 and prescale P is 2 or more, ref_tick is a one-cycle pulse that repeats every P system clocks.
- R3: A prescale of 0 or 1 divides by one, so ref_tick is high on every enabled cycle.
- R4: SCL is high for H reference ticks and low for L ticks, where H = divider[15:8] and L = divider[7:0]. With prescale P the SCL period is P*(H+L) system clocks, and SCL changes level only in the cycle after a reference tick.
- R5: A divider half of zero acts as one tick.
- R6: sample_stb pulses for one cycle once per high phase. It comes on the tick at which ceil(H/2) ticks of the high phase have elapsed, and it is never high except after a high-phase tick.
- R7: drive_stb pulses for one cycle, in exactly the first cycle in which scl_out is 0.
- R8: When enable is sampled low, scl_out is 1 in the next cycle, with no tick or strobe. On re-enable the generator starts a full high phase.
- R9: While hold is 1 during the low phase, reference ticks are not counted and SCL stays low.
- R10: Each half length is taken from the divider when its phase starts. A change to the divider during a phase takes effect from the next phase of that kind.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the generator while 1 |
| prescale | input | 7 | System clocks per reference tick |
| divider | input | 16 | High-half ticks in [15:8], low-half ticks in [7:0] |
| hold | input | 1 | Freezes the low-phase count |
| ref_tick | output | 1 | One-cycle reference tick |
| scl_out | output | 1 | SCL level request, 1 = released high |
| sample_stb | output | 1 | Strobe at the middle of the high phase |
| drive_stb | output | 1 | Strobe at the start of the low phase |

## Verification
Some properties are checked on every cycle by the assertions. A tick never repeats back to back when prescale is above one. Disabling quiets every output at the next edge. SCL only changes after a tick, and hold keeps SCL low. The strobes line up with the high phase and with the falling edge.

Other behaviour needs a reference over time, so only the bench scenarios can show it:
- the exact period for several prescale and divider pairs;
- the placement of the sample strobe within the high phase;
- zero halves acting as one tick;
- the restart after re-enable;
- the rule that a divider written mid-phase affects only the next phase.

The bench covers these with a behavioural model that it compares on every clock, plus duration measurements.

// File: rtl/scl_clk_pkg.sv
`timescale 1ns/1ps
package scl_clk_pkg;
  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } scl_phase_e;
endpackage

// File: rtl/scl_prescaler.sv
`timescale 1ns/1ps
module scl_prescaler #(
  parameter int PRE_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [PRE_W-1:0] prescale,
  output logic             tick
);
  logic [PRE_W-1:0] pcnt;
  logic [PRE_W-1:0] last_cnt;

  // values 0 and 1 both mean divide-by-one
  assign last_cnt = (prescale <= PRE_W'(1)) ? '0 : prescale - PRE_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      pcnt <= '0;
      tick <= 1'b0;
    end else if (pcnt >= last_cnt) begin
      pcnt <= '0;
      tick <= 1'b1;
    end else begin
      pcnt <= pcnt + PRE_W'(1);
      tick <= 1'b0;
    end
  end

  assert_tick_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && enable && prescale > PRE_W'(1)) |=> !tick);

  assert_tick_quiet_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !tick);
endmodule

// File: rtl/scl_phase_gen.sv
`timescale 1ns/1ps
module scl_phase_gen
  import scl_clk_pkg::*;
#(
  parameter int HALF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              tick,
  input  logic              hold,
  input  logic [HALF_W-1:0] hi_raw,
  input  logic [HALF_W-1:0] lo_raw,
  output logic              scl,
  output logic              sample_stb,
  output logic              drive_stb
);
  scl_phase_e        phase_q;
  logic              armed_q;
  logic [HALF_W-1:0] cnt_q;
  logic [HALF_W-1:0] mid_q;
  logic [HALF_W-1:0] hi_len;
  logic [HALF_W-1:0] lo_len;
  logic [HALF_W-1:0] hi_mid;
  logic              last_tick;

  assign hi_len    = (hi_raw == '0) ? HALF_W'(1) : hi_raw;
  assign lo_len    = (lo_raw == '0) ? HALF_W'(1) : lo_raw;
  assign hi_mid    = (hi_len >> 1) + HALF_W'(1);
  assign last_tick = (cnt_q <= HALF_W'(1));
  assign scl       = (phase_q == PH_HIGH);

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      phase_q    <= PH_HIGH;
      armed_q    <= 1'b0;
      cnt_q      <= '0;
      mid_q      <= '0;
      sample_stb <= 1'b0;
      drive_stb  <= 1'b0;
    end else begin
      sample_stb <= 1'b0;
      drive_stb  <= 1'b0;
      if (!armed_q) begin
        // first enabled cycle: load a full high phase
        armed_q <= 1'b1;
        cnt_q   <= hi_len;
        mid_q   <= hi_mid;
      end else if (tick) begin
        if (phase_q == PH_HIGH) begin
          sample_stb <= (cnt_q == mid_q);
          if (last_tick) begin
            phase_q   <= PH_LOW;
            drive_stb <= 1'b1;
            cnt_q     <= lo_len;
          end else begin
            cnt_q <= cnt_q - HALF_W'(1);
          end
        end else if (!hold) begin
          if (last_tick) begin
            phase_q <= PH_HIGH;
            cnt_q   <= hi_len;
            mid_q   <= hi_mid;
          end else begin
            cnt_q <= cnt_q - HALF_W'(1);
          end
        end
      end
    end
  end

  assert_release_on_disable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (scl && !sample_stb && !drive_stb));

  assert_drive_at_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    drive_stb |-> (!scl && $past(scl)));

  assert_fall_has_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl) |-> drive_stb);

  assert_sample_in_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> ($past(scl) && $past(tick)));

  assert_hold_keeps_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !scl && enable) |=> !scl);

  assert_edge_after_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((scl != $past(scl)) && $past(enable)) |-> $past(tick));
endmodule

// File: rtl/scl_clkgen.sv
`timescale 1ns/1ps
module scl_clkgen #(
  parameter int PRE_W  = 7,
  parameter int HALF_W = 8,
  localparam int DIV_W = 2 * HALF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [PRE_W-1:0] prescale,
  input  logic [DIV_W-1:0] divider,
  input  logic             hold,
  output logic             ref_tick,
  output logic             scl_out,
  output logic             sample_stb,
  output logic             drive_stb
);
  scl_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .prescale (prescale),
    .tick     (ref_tick)
  );

  scl_phase_gen #(.HALF_W(HALF_W)) u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .tick       (ref_tick),
    .hold       (hold),
    .hi_raw     (divider[DIV_W-1:HALF_W]),
    .lo_raw     (divider[HALF_W-1:0]),
    .scl        (scl_out),
    .sample_stb (sample_stb),
    .drive_stb  (drive_stb)
  );
endmodule

// File: tb/scl_clkgen_test.sv
`timescale 1ns/1ps
module scl_clkgen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [6:0]  prescale = 7'd5;
  logic [15:0] divider = 16'h0302;
  logic        hold = 1'b0;
  logic        ref_tick, scl_out, sample_stb, drive_stb;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  scl_clkgen uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .prescale(prescale),
    .divider(divider), .hold(hold), .ref_tick(ref_tick), .scl_out(scl_out),
    .sample_stb(sample_stb), .drive_stb(drive_stb)
  );

  // behavioural reference model
  int m_pc, m_cnt, m_mid, m_lim, m_h, m_l;
  bit m_tick = 0, m_scl = 1, m_armed = 0, m_s = 0, m_d = 0, m_old;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pc = 0; m_tick = 0; m_scl = 1; m_armed = 0; m_cnt = 0; m_mid = 0; m_s = 0; m_d = 0;
    end else begin
      m_old = m_tick;
      m_h = (divider[15:8] == 0) ? 1 : int'(divider[15:8]);
      m_l = (divider[7:0] == 0) ? 1 : int'(divider[7:0]);
      if (!enable) begin
        m_pc = 0; m_tick = 0;
      end else begin
        m_lim = (prescale <= 1) ? 0 : int'(prescale) - 1;
        if (m_pc >= m_lim) begin m_pc = 0; m_tick = 1; end
        else begin m_pc++; m_tick = 0; end
      end
      m_s = 0; m_d = 0;
      if (!enable) begin
        m_scl = 1; m_armed = 0; m_cnt = 0; m_mid = 0;
      end else if (!m_armed) begin
        m_armed = 1; m_cnt = m_h; m_mid = m_h / 2 + 1;
      end else if (m_old) begin
        if (m_scl) begin
          m_s = (m_cnt == m_mid);
          if (m_cnt <= 1) begin m_scl = 0; m_d = 1; m_cnt = m_l; end
          else m_cnt--;
        end else if (!hold) begin
          if (m_cnt <= 1) begin m_scl = 1; m_cnt = m_h; m_mid = m_h / 2 + 1; end
          else m_cnt--;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(ref_tick == m_tick, "R2 ref_tick", ref_tick, m_tick);
      check(scl_out == m_scl, "R4 scl_out", scl_out, m_scl);
      check(sample_stb == m_s, "R6 sample_stb", sample_stb, m_s);
      check(drive_stb == m_d, "R7 drive_stb", drive_stb, m_d);
    end
  end

  task automatic wait_scl(input bit v);
    while (scl_out != v) @(negedge clk);
  endtask

  // one full period starting at a rising edge; also counts strobes
  task automatic period(output int n, output int ns, output int nd);
    wait_scl(0); wait_scl(1);
    n = 0; ns = 0; nd = 0;
    do begin @(negedge clk); n++; ns += sample_stb; nd += drive_stb; end while (scl_out);
    while (!scl_out) begin @(negedge clk); n++; ns += sample_stb; nd += drive_stb; end
  endtask

  task automatic run_len(input bit v, output int n);
    n = 1;
    @(negedge clk);
    while (scl_out == v) begin n++; @(negedge clk); end
  endtask

  initial begin
    #(20 * 190000);
    errors++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n, ns, nd, t;
    repeat (3) @(negedge clk);
    check(scl_out && !ref_tick && !sample_stb && !drive_stb, "R1 reset state", scl_out, 1);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check(scl_out && !ref_tick && !sample_stb && !drive_stb, "R1 idle before enable", scl_out, 1);
    enable = 1;

    period(n, ns, nd);
    check(n == 25, "R4 period P5 H3 L2", n, 25);
    check(ns == 1, "R6 one sample strobe per period", ns, 1);
    check(nd == 1, "R7 one drive strobe per period", nd, 1);

    prescale = 7'd0; repeat (3) @(negedge clk);
    t = 0; for (int i = 0; i < 10; i++) begin @(negedge clk); t += ref_tick; end
    check(t == 10, "R3 prescale 0 ticks", t, 10);
    prescale = 7'd1; repeat (3) @(negedge clk);
    t = 0; for (int i = 0; i < 10; i++) begin @(negedge clk); t += ref_tick; end
    check(t == 10, "R3 prescale 1 ticks", t, 10);

    prescale = 7'd2; divider = 16'h0000;
    period(n, ns, nd); period(n, ns, nd);
    check(n == 4, "R5 zero halves period", n, 4);

    prescale = 7'd1; divider = 16'h0404;
    wait_scl(1); wait_scl(0);
    hold = 1;
    t = 0; for (int i = 0; i < 20; i++) begin @(negedge clk); t += scl_out; end
    check(t == 0, "R9 hold keeps scl low", t, 0);
    hold = 0;
    run_len(0, n);
    check(n > 0 && n <= 5, "R9 low resumes after hold", n, 4);

    divider = 16'h0A0A;
    period(n, ns, nd);
    wait_scl(1); wait_scl(0);
    divider = 16'h0203;
    run_len(0, n);
    check(n == 10, "R10 low latched at phase start", n, 10);
    run_len(1, n);
    check(n == 2, "R10 new high length", n, 2);
    run_len(0, n);
    check(n == 3, "R10 new low length", n, 3);

    prescale = 7'd3; divider = 16'h0505;
    period(n, ns, nd);
    wait_scl(1); repeat (2) @(negedge clk);
    enable = 0; @(negedge clk);
    check(scl_out && !ref_tick && !sample_stb && !drive_stb, "R8 disable in high", scl_out, 1);
    enable = 1; wait_scl(0);
    enable = 0; @(negedge clk);
    check(scl_out == 1, "R8 disable in low releases scl", scl_out, 1);
    repeat (2) @(negedge clk);
    enable = 1;
    t = 0; @(negedge clk);
    while (scl_out) begin t++; @(negedge clk); end
    check(t >= 14 && t <= 17, "R8 full high phase after re-enable", t, 16);
    period(n, ns, nd);
    check(n == 30, "R8 period after re-enable", n, 30);

    prescale = 7'd100; divider = 16'h3232;
    wait_scl(1);
    while (!ref_tick) @(negedge clk);
    t = 0; @(negedge clk);
    while (!ref_tick) begin t++; @(negedge clk); end
    check(t + 1 == 100, "R2 tick spacing 100", t + 1, 100);
    period(n, ns, nd);
    check(n == 10000, "R4 period P100 H50 L50", n, 10000);
    check(ns == 1 && nd == 1, "R6 strobes at slow rate", ns + nd, 2);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule